// File: doc/BRIEF.md
# Line-Aligned Cache Maintenance Command Sequencer

This block turns a byte-range maintenance request into the series of commands that a cache maintenance queue accepts. A request carries a start address, an end address (exclusive) and an operation code. The block widens the range to whole cache lines and cuts it into chunks no larger than the queue can take in one command. It issues the chunks one at a time and waits for a completion pulse after each one. It closes every request with a sync command.

When the range is so large that its size wraps the address space, the block sends one whole-cache command instead of range commands. Invalidation gets special care. A line that is only partly covered by the range may hold other live data, so that line is flushed (written back and dropped) rather than invalidated. Only the fully covered interior lines are invalidated.

The line size is 2^LINE_LG bytes and the chunk limit is 2^CHUNK_LG minus one line. The address width is ADDR_W. Operation codes: 0 invalidate, 1 clean, 2 flush; codes 3 to 7 are passed through unchanged as range operations. Command scopes: 0 range, 1 whole cache, 2 sync.

Top module: `range_maint_splitter`

## Requirements
- R1: Every range command carries a line-aligned address; for non-invalidate operations the first chunk starts at the request start rounded down to a line boundary.
- R2: The total size covered by range commands is (end minus aligned start), rounded up to a multiple of the line size; every range command size is a non-zero multiple of the line size.
- R3: When (end minus aligned start), taken modulo 2^ADDR_W, is at least 2^ADDR_W minus one line, a single command with scope 1, address 0, size 0 and the request's operation is issued instead of range commands.
- R4: The range is issued as successive chunks of at most 2^CHUNK_LG minus one line bytes; each chunk begins where the previous one ended and only the last chunk may be smaller.
- R5: For invalidate (op 0) with an unaligned start, the first command is a flush (op 2) of the line holding the start, with size one line; the start then moves to the next line.
- R6: For invalidate with an unaligned end, after the start handling and while start is below end, a flush of the line holding the end is issued and the end is rounded down.
- R7: For invalidate, if start is not below end after either edge step, no invalidate command is sent and only the sync follows.
- R8: Every request ends with exactly one sync command: scope 2, address 0, size 0, op 0.
- R9: A command stays on the output, with unchanged fields, until cmd_done_i is high in a cycle where cmd_valid_o is high; a done pulse while no command is pending has no effect.
- R10: After reset req_ready_o is high and cmd_valid_o is low; a request is accepted only while req_ready_o is high, and req_ready_o returns high in the cycle after the sync completes.
- R11: A request with end equal to start produces only the sync command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request accepted this cycle if valid |
| req_start_i | input | ADDR_W | First byte address of the range |
| req_end_i | input | ADDR_W | Address one past the last byte |
| req_op_i | input | 3 | Operation code |
| cmd_valid_o | output | 1 | Command pending on the output |
| cmd_scope_o | output | 2 | 0 range, 1 whole cache, 2 sync |
| cmd_addr_o | output | ADDR_W | Line-aligned command address |
| cmd_size_o | output | ADDR_W | Command size in bytes |
| cmd_op_o | output | 3 | Command operation code |
| cmd_done_i | input | 1 | Completion pulse for the pending command |

## Verification
The bench builds the block with ADDR_W=16, LINE_LG=4 and CHUNK_LG=8, so a line is 16 bytes, a chunk holds at most 240 bytes and the whole-cache threshold sits at 65520. With these values a few hundred bytes already split into several chunks. Ranges near the top of the address space reach both the whole-cache fallback and the carry out of the start advance. The completion pulse is delayed by zero to two cycles, which exercises the hold rule on each command.

// File: rtl/rms_pkg.sv
package rms_pkg;
  localparam logic [1:0] SCOPE_RANGE = 2'd0;
  localparam logic [1:0] SCOPE_ALL   = 2'd1;
  localparam logic [1:0] SCOPE_SYNC  = 2'd2;

  localparam logic [2:0] OP_INV   = 3'd0;
  localparam logic [2:0] OP_FLUSH = 3'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EDGE_LO, ST_CHK, ST_EDGE_HI, ST_BODY, ST_CHUNK, ST_ALL, ST_SYNC
  } state_e;
endpackage

// File: rtl/rms_line_math.sv
module rms_line_math #(
  parameter int ADDR_W  = 32,
  parameter int LINE_LG = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] down_o,
  output logic              partial_o
);
  assign down_o    = {addr_i[ADDR_W-1:LINE_LG], {LINE_LG{1'b0}}};
  assign partial_o = |addr_i[LINE_LG-1:0];
endmodule

// File: rtl/rms_body_plan.sv
module rms_body_plan #(
  parameter int ADDR_W  = 32,
  parameter int LINE_LG = 7
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic              whole_o,
  output logic [ADDR_W-1:0] size_o
);
  localparam logic [ADDR_W-1:0] LMASK = {{(ADDR_W-LINE_LG){1'b0}}, {LINE_LG{1'b1}}};
  localparam logic [ADDR_W-1:0] WRAP_TH = ~LMASK;

  logic [ADDR_W-1:0] diff;
  assign diff    = end_i - base_i;
  assign whole_o = diff >= WRAP_TH;
  // only used when !whole_o, so the round-up cannot carry out
  assign size_o  = (diff + LMASK) & ~LMASK;
endmodule

// File: rtl/rms_chunk.sv
module rms_chunk #(
  parameter int ADDR_W   = 32,
  parameter int LINE_LG  = 7,
  parameter int CHUNK_LG = 22
) (
  input  logic [ADDR_W-1:0] rem_i,
  output logic [ADDR_W-1:0] take_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] CMAX = (ONE << CHUNK_LG) - (ONE << LINE_LG);

  assign last_o = rem_i <= CMAX;
  assign take_o = last_o ? rem_i : CMAX;
endmodule

// File: rtl/range_maint_splitter.sv
module range_maint_splitter #(
  parameter int ADDR_W   = 32,
  parameter int LINE_LG  = 7,
  parameter int CHUNK_LG = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_start_i,
  input  logic [ADDR_W-1:0] req_end_i,
  input  logic [2:0]        req_op_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_scope_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [ADDR_W-1:0] cmd_size_o,
  output logic [2:0]        cmd_op_o,
  input  logic              cmd_done_i
);
  import rms_pkg::*;

  localparam logic [ADDR_W-1:0] ONE_W  = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] LINE_W = ONE_W << LINE_LG;
  localparam logic [ADDR_W:0]   LINE_X = {1'b0, LINE_W};
  localparam logic [ADDR_W-1:0] CMAX   = (ONE_W << CHUNK_LG) - LINE_W;

  state_e            st_q;
  logic [ADDR_W:0]   s_q;    // extra bit: start may step past the top line
  logic [ADDR_W-1:0] e_q, cur_q, rem_q;
  logic [2:0]        op_q;

  logic [ADDR_W-1:0] s_down, e_down, req_down, plan_size, take;
  logic              s_part, e_part, req_part, plan_whole, last_chunk, fire;

  rms_line_math #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG)) u_lm_req (
    .addr_i(req_start_i), .down_o(req_down), .partial_o(req_part));
  rms_line_math #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG)) u_lm_s (
    .addr_i(s_q[ADDR_W-1:0]), .down_o(s_down), .partial_o(s_part));
  rms_line_math #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG)) u_lm_e (
    .addr_i(e_q), .down_o(e_down), .partial_o(e_part));

  rms_body_plan #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG)) u_plan (
    .base_i(s_down), .end_i(e_q), .whole_o(plan_whole), .size_o(plan_size));

  rms_chunk #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG), .CHUNK_LG(CHUNK_LG)) u_chunk (
    .rem_i(rem_q), .take_o(take), .last_o(last_chunk));

  assign req_ready_o = (st_q == ST_IDLE);
  assign cmd_valid_o = st_q inside {ST_EDGE_LO, ST_EDGE_HI, ST_CHUNK, ST_ALL, ST_SYNC};
  assign fire        = cmd_valid_o && cmd_done_i;

  always_comb begin
    cmd_scope_o = SCOPE_RANGE;
    cmd_addr_o  = '0;
    cmd_size_o  = '0;
    cmd_op_o    = op_q;
    unique case (st_q)
      ST_EDGE_LO: begin cmd_addr_o = s_down; cmd_size_o = LINE_W; cmd_op_o = OP_FLUSH; end
      ST_EDGE_HI: begin cmd_addr_o = e_down; cmd_size_o = LINE_W; cmd_op_o = OP_FLUSH; end
      ST_CHUNK:   begin cmd_addr_o = cur_q;  cmd_size_o = take; end
      ST_ALL:     cmd_scope_o = SCOPE_ALL;
      ST_SYNC:    begin cmd_scope_o = SCOPE_SYNC; cmd_op_o = '0; end
      default:    cmd_op_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      s_q   <= '0;
      e_q   <= '0;
      cur_q <= '0;
      rem_q <= '0;
      op_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          s_q  <= {1'b0, req_start_i};
          e_q  <= req_end_i;
          op_q <= req_op_i;
          if (req_op_i != OP_INV) st_q <= ST_BODY;
          else                    st_q <= req_part ? ST_EDGE_LO : ST_CHK;
        end
        ST_EDGE_LO: if (fire) begin
          s_q  <= {1'b0, s_down} + LINE_X;
          st_q <= ST_CHK;
        end
        ST_CHK: begin
          if (s_q >= {1'b0, e_q}) st_q <= ST_SYNC;
          else if (e_part)        st_q <= ST_EDGE_HI;
          else                    st_q <= ST_BODY;
        end
        ST_EDGE_HI: if (fire) begin
          e_q  <= e_down;
          st_q <= (s_q >= {1'b0, e_down}) ? ST_SYNC : ST_BODY;
        end
        ST_BODY: begin
          cur_q <= s_down;
          rem_q <= plan_size;
          if (plan_whole)          st_q <= ST_ALL;
          else if (plan_size == 0) st_q <= ST_SYNC;
          else                     st_q <= ST_CHUNK;
        end
        ST_CHUNK: if (fire) begin
          cur_q <= cur_q + take;
          rem_q <= rem_q - take;
          st_q  <= last_chunk ? ST_SYNC : ST_CHUNK;
        end
        ST_ALL:  if (fire) st_q <= ST_SYNC;
        ST_SYNC: if (fire) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic unused_req;
  assign unused_req = |req_down;

  p_range_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_scope_o == SCOPE_RANGE |-> cmd_addr_o[LINE_LG-1:0] == '0);
  p_size_lines_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_scope_o == SCOPE_RANGE |->
      cmd_size_o[LINE_LG-1:0] == '0 && cmd_size_o != '0);
  p_whole_fields_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_scope_o == SCOPE_ALL |-> cmd_addr_o == '0 && cmd_size_o == '0);
  p_chunk_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_scope_o == SCOPE_RANGE |-> cmd_size_o <= CMAX);
  p_edge_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_scope_o == SCOPE_RANGE && op_q == OP_INV && cmd_op_o != OP_INV
      |-> cmd_op_o == OP_FLUSH && cmd_size_o == LINE_W);
  p_sync_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_scope_o == SCOPE_SYNC && cmd_done_i |=> req_ready_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_addr_o) &&
      $stable(cmd_size_o) && $stable(cmd_scope_o) && $stable(cmd_op_o));
  p_ready_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !cmd_valid_o);
endmodule

// File: tb/range_maint_splitter_test.sv
module range_maint_splitter_test;
  localparam int W = 16, LG = 4, CLG = 8;
  localparam int LINE = 1 << LG;
  localparam int CMAX = (1 << CLG) - LINE;
  localparam int SPACE = 1 << W;

  logic clk = 0, rst_ni = 0;
  logic req_valid = 0, cmd_done = 0;
  logic [W-1:0] req_start = '0, req_end = '0;
  logic [2:0] req_op = '0;
  logic req_ready, cmd_valid;
  logic [1:0] cmd_scope;
  logic [W-1:0] cmd_addr, cmd_size;
  logic [2:0] cmd_op;

  int n_run = 0, n_fail = 0;
  int q_scope[$], q_addr[$], q_size[$], q_op[$];

  always #10 clk = ~clk;

  range_maint_splitter #(.ADDR_W(W), .LINE_LG(LG), .CHUNK_LG(CLG)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_start_i(req_start), .req_end_i(req_end), .req_op_i(req_op),
    .cmd_valid_o(cmd_valid), .cmd_scope_o(cmd_scope), .cmd_addr_o(cmd_addr),
    .cmd_size_o(cmd_size), .cmd_op_o(cmd_op), .cmd_done_i(cmd_done));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int sc, input int a, input int sz, input int op);
    q_scope.push_back(sc); q_addr.push_back(a); q_size.push_back(sz); q_op.push_back(op);
  endtask

  // reference from the requirements, in plain integer arithmetic
  task automatic build(input int s, input int e, input int op);
    int a, sz, c;
    if (op == 0) begin
      if (s % LINE != 0) begin push(0, s - s % LINE, LINE, 2); s = s - s % LINE + LINE; end
      if (s >= e) begin push(2, 0, 0, 0); return; end
      if (e % LINE != 0) begin push(0, e - e % LINE, LINE, 2); e = e - e % LINE; end
      if (s >= e) begin push(2, 0, 0, 0); return; end
    end
    a  = s - s % LINE;
    sz = (e - a + SPACE) % SPACE;
    if (sz >= SPACE - LINE) push(1, 0, 0, op);
    else begin
      sz = (sz + LINE - 1) / LINE * LINE;
      while (sz > 0) begin
        c = (sz < CMAX) ? sz : CMAX;
        push(0, a, c, op);
        a += c; sz -= c;
      end
    end
    push(2, 0, 0, 0);
  endtask

  task automatic run_req(input string req, input int s, input int e, input int op);
    int k = 0;
    build(s, e, op);
    @(negedge clk);
    check(req_ready === 1'b1, "R10", "ready before request", req_ready, 1);
    req_start = W'(s); req_end = W'(e); req_op = 3'(op); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (q_scope.size() > 0) begin
      int sc = q_scope.pop_front(), a = q_addr.pop_front();
      int sz = q_size.pop_front(), o = q_op.pop_front();
      int w = 0;
      while (cmd_valid !== 1'b1 && w < 50) begin @(negedge clk); w++; end
      if (cmd_valid !== 1'b1) begin
        check(0, req, "command missing", 0, 1);
        q_scope.delete(); q_addr.delete(); q_size.delete(); q_op.delete();
        return;
      end
      check(cmd_scope == 2'(sc) && cmd_addr == W'(a) && cmd_size == W'(sz) && cmd_op == 3'(o),
            req, $sformatf("cmd %0d scope/addr/size/op", k),
            {cmd_scope, cmd_addr, cmd_size, cmd_op}, {2'(sc), W'(a), W'(sz), 3'(o)});
      check(req_ready === 1'b0, "R10", "ready while busy", req_ready, 0);
      repeat (k % 3) @(negedge clk);
      check(cmd_valid === 1'b1, "R9", "command held until done", cmd_valid, 1);
      cmd_done = 1;
      @(negedge clk);
      cmd_done = 0;
      k++;
    end
    check(cmd_valid === 1'b0 && req_ready === 1'b1, "R10", "idle after sync",
          {cmd_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && cmd_valid === 1'b0, "R10", "reset state",
          {req_ready, cmd_valid}, 2'b10);
    rst_ni = 1;
    @(negedge clk);
    // R9: stray done while idle has no effect
    cmd_done = 1; @(negedge clk); cmd_done = 0; @(negedge clk);
    check(cmd_valid === 1'b0 && req_ready === 1'b1, "R9", "stray done ignored",
          {cmd_valid, req_ready}, 2'b01);
    run_req("R1_R2", 16'h0105, 16'h0123, 2);
    run_req("R4",    16'h1000, 16'h1400, 1);
    run_req("R3",    16'h0020, 16'h0010, 3);
    run_req("R3",    16'h0000, 16'hfff0, 2);
    run_req("R4",    16'h0005, 16'h0707, 5);
    run_req("R5_R6", 16'h0203, 16'h02f9, 0);
    run_req("R7",    16'h0305, 16'h030a, 0);
    run_req("R7",    16'h0400, 16'h0408, 0);
    run_req("R4",    16'h0500, 16'h0600, 0);
    run_req("R11",   16'h0700, 16'h0700, 1);
    run_req("R11",   16'h0700, 16'h0700, 0);
    run_req("R5",    16'hfff5, 16'hfffa, 0);
    run_req("R8",    16'h0810, 16'h0811, 7);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule